// File: doc/BRIEF.md
# Redundant Binary to Two's Complement Converter

The block turns an N-digit signed-digit number with digits in {-1, 0, +1} into an ordinary N-bit two's complement word. Each digit arrives as two bits on parallel vectors. A bit on `dig_pos` marks +1, a bit on `dig_neg` marks -1, and both low marks 0. The conversion is the subtraction `dig_pos - dig_neg`. It is built as `dig_pos + ~dig_neg + 1`, and any carry out of the top digit is dropped.

Carries are not resolved at every bit. The digits are grouped into carry-select sections of `SEC` digits each, and the last section may be narrower. Every section forms both candidate sums, one for carry-in 0 and one for carry-in 1. A mixed-radix lookahead tree over the section generate/propagate pairs supplies one carry per section boundary. The tree has one radix-3 level followed by radix-2 levels of doubling span. That carry selects the correct candidate for the section. Section 0 always sees carry-in 1.

With `OUT_REG = 0` the path from inputs to `result` is purely combinational. With `OUT_REG = 1` a single register stage follows, and it clears on reset.

Top module: `rb2tc_converter`

## Requirements
- R1: `result` equals the sum over i of (dig_pos[i] - dig_neg[i])·2^i, taken modulo 2^N. A set bit in `dig_pos` is digit +1, a set bit in `dig_neg` is digit -1, and both clear is digit 0.
- R2: The pair dig_pos[i] = dig_neg[i] = 1 is illegal at every digit position. Callers never drive it.
- R3: An input with every digit 0 yields a `result` of all zeros.
- R4: Every digit -1 yields `result` = 1. Every digit +1 yields `result` with all N bits set.
- R5: The carry entering section k (k ≥ 1) is 1 exactly when the low k·SEC digits have a value of zero or more. Patterns whose sign flips across a section boundary convert correctly.
- R6: The carry out of digit N-1 is discarded, and bit N-1 of `result` is the sign bit. A lone +1 or a lone -1 at digit N-1 both give only bit N-1 set.
- R7: When N is not a multiple of SEC, the last section covers only the remaining digits and still converts correctly (for example N = 17 with SEC = 4).
- R8: With OUT_REG = 1, `result` shows the conversion of the inputs present at the previous rising clock edge and is zero while `rst_n` is low. With OUT_REG = 0, `result` follows the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| dig_pos | input | N | Bit i set means digit i is +1 |
| dig_neg | input | N | Bit i set means digit i is -1 |
| result | output | N | Two's complement value of the digit vector |

## Verification
A wrong section generate or propagate term, or a wrong span in the lookahead tree, corrupts the carry into one or more later sections. At the ports this shows as every bit of the affected section being wrong by one unit in that section's lowest place. It appears on the first input pattern whose value changes sign across that boundary. A broken candidate-sum ripple shows within a single section. In the combinational variant either fault is visible the moment the inputs settle. In the registered variant it is visible one clock later, and a fault in the register stage shows as a result that lags or leads by a cycle.

// File: rtl/rb2tc_converter.sv
module rb2tc_converter #(
  parameter int N       = 64,
  parameter int SEC     = 6,
  parameter bit OUT_REG = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] dig_pos,
  input  logic [N-1:0] dig_neg,
  output logic [N-1:0] result
);
  localparam int NS = (N + SEC - 1) / SEC;

  function automatic int radix2_levels(input int ns);
    int span = 3;
    int cnt  = 0;
    while (span < ns) begin
      span = span * 2;
      cnt++;
    end
    return cnt;
  endfunction

  localparam int NR2 = radix2_levels(NS);
  localparam int NL  = 1 + NR2;

  logic [N-1:0]  g, p, h;
  logic [N-1:0]  sum0, sum1, comb_res;
  logic [NS-1:0] sec_g, sec_p, cin_sec;
  logic [NS-1:0] tg [NL+1];
  logic [NS-1:0] tp [NL+1];

  assign g = dig_pos;
  assign p = ~dig_neg;
  assign h = ~(dig_pos | dig_neg);

  always_comb begin
    sum0  = '0;
    sum1  = '0;
    sec_g = '0;
    sec_p = '0;
    for (int s = 0; s < NS; s++) begin
      logic c0, c1, pa;
      c0 = 1'b0;
      c1 = 1'b1;
      pa = 1'b1;
      for (int b = 0; b < SEC; b++) begin
        if (s * SEC + b < N) begin
          sum0[s*SEC+b] = h[s*SEC+b] ^ c0;
          sum1[s*SEC+b] = h[s*SEC+b] ^ c1;
          c0 = g[s*SEC+b] | (p[s*SEC+b] & c0);
          c1 = g[s*SEC+b] | (p[s*SEC+b] & c1);
          pa = pa & p[s*SEC+b];
        end
      end
      sec_g[s] = c0;
      sec_p[s] = pa;
    end
  end

  always_comb begin
    tg[0] = sec_g;
    tp[0] = sec_p;
    for (int i = 0; i < NS; i++) begin
      if (i >= 2) begin
        tg[1][i] = tg[0][i] | (tp[0][i] & tg[0][i-1]) | (tp[0][i] & tp[0][i-1] & tg[0][i-2]);
        tp[1][i] = tp[0][i] & tp[0][i-1] & tp[0][i-2];
      end else if (i == 1) begin
        tg[1][i] = tg[0][1] | (tp[0][1] & tg[0][0]);
        tp[1][i] = tp[0][1] & tp[0][0];
      end else begin
        tg[1][i] = tg[0][0];
        tp[1][i] = tp[0][0];
      end
    end
    for (int l = 0; l < NR2; l++) begin
      for (int i = 0; i < NS; i++) begin
        if (i >= (3 << l)) begin
          tg[l+2][i] = tg[l+1][i] | (tp[l+1][i] & tg[l+1][i-(3<<l)]);
          tp[l+2][i] = tp[l+1][i] & tp[l+1][i-(3<<l)];
        end else begin
          tg[l+2][i] = tg[l+1][i];
          tp[l+2][i] = tp[l+1][i];
        end
      end
    end
  end

  always_comb begin
    cin_sec[0] = 1'b1;
    for (int k = 1; k < NS; k++)
      cin_sec[k] = tg[NL][k-1] | tp[NL][k-1];
    for (int i = 0; i < N; i++)
      comb_res[i] = cin_sec[i/SEC] ? sum1[i] : sum0[i];
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) result <= '0;
        else        result <= comb_res;

      // R8
      reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> result == $past(dig_pos - dig_neg));
    end else begin : g_comb
      assign result = comb_res;
    end
  endgenerate

  // R2
  no_both_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_pos & dig_neg) == '0);

  // R1
  value_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_res == dig_pos - dig_neg);

  // R3
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_pos | dig_neg) == '0 |-> comb_res == '0);

  generate
    for (genvar k = 1; k < NS; k++) begin : g_cchk
      // R5
      boundary_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cin_sec[k] == (dig_pos[k*SEC-1:0] >= dig_neg[k*SEC-1:0]));
    end
  endgenerate
endmodule

// File: tb/rb2tc_converter_tb.sv
module rb2tc_converter_tb_top;
  localparam int CLK_P = 10;
  localparam int NA = 64;
  localparam int NB = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NA-1:0] a_pos = '0, a_neg = '0, a_res;
  logic [NB-1:0] b_pos = '0, b_neg = '0, b_res;
  logic [NB-1:0] b_prev_exp;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rb2tc_converter #(.N(NA), .SEC(6), .OUT_REG(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .dig_pos(a_pos), .dig_neg(a_neg), .result(a_res));

  rb2tc_converter #(.N(NB), .SEC(4), .OUT_REG(1'b1)) dut_reg_i (
    .clk(clk), .rst_n(rst_n), .dig_pos(b_pos), .dig_neg(b_neg), .result(b_res));

  function automatic logic [NA-1:0] ref_a(input logic [NA-1:0] ps, input logic [NA-1:0] ng);
    logic [NA-1:0] acc = '0;
    for (int i = 0; i < NA; i++) begin
      if (ps[i]) acc = acc + (64'd1 << i);
      if (ng[i]) acc = acc - (64'd1 << i);
    end
    return acc;
  endfunction

  function automatic logic [NB-1:0] ref_b(input logic [NB-1:0] ps, input logic [NB-1:0] ng);
    logic [NB-1:0] acc = '0;
    for (int i = 0; i < NB; i++) begin
      if (ps[i]) acc = acc + (NB'(1) << i);
      if (ng[i]) acc = acc - (NB'(1) << i);
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [NA-1:0] ps, input logic [NA-1:0] ng);
    @(negedge clk);
    a_pos = ps;
    a_neg = ng;
    b_pos = ps[NB-1:0];
    b_neg = ng[NB-1:0];
    #1;
    check(req, a_res, ref_a(ps, ng));
    check("R8 hold", {47'd0, b_res}, {47'd0, b_prev_exp});
    @(posedge clk);
    #1;
    check({req, " R7 R8"}, {47'd0, b_res}, {47'd0, ref_b(ps[NB-1:0], ng[NB-1:0])});
    b_prev_exp = ref_b(ps[NB-1:0], ng[NB-1:0]);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NA-1:0] rp, rn;
    void'($urandom(32'h5eed));
    b_prev_exp = '0;
    #(CLK_P * 2);
    #1;
    check("R8 reset", {47'd0, b_res}, 64'd0);
    check("R3 reset", a_res, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    apply("R3 zeros", '0, '0);
    apply("R4 all -1", '0, '1);
    check("R4 value", a_res, 64'd1);
    apply("R4 all +1", '1, '0);
    check("R4 value", a_res, '1);
    apply("R6 msd +1", 64'd1 << 63, '0);
    check("R6 value", a_res, 64'd1 << 63);
    apply("R6 msd -1", '0, 64'd1 << 63);
    check("R6 value", a_res, 64'd1 << 63);
    apply("R5 boundary", 64'd1 << 6, 64'd1);
    check("R5 value", a_res, 64'd63);
    apply("R5 zero low", 64'h0000_0000_0000_1041, 64'h0000_0000_0000_0820);
    apply("R5 neg chain", 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0fff);
    apply("R1 alternate", 64'h5555_5555_5555_5555, 64'haaaa_aaaa_aaaa_aaaa);

    for (int n = 0; n < 400; n++) begin
      rp = {$urandom, $urandom};
      rn = {$urandom, $urandom};
      if (n % 3 == 0) rn = rn & {$urandom, $urandom};
      if (n % 3 == 1) rp = rp & {$urandom, $urandom};
      rn = rn & ~rp;
      apply("R1 R2 random", rp, rn);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule